// File: doc/BRIEF.md
# Mixed-Width Dual-Clock RAM

This block is a simple dual-port memory. It has one port that only writes and one port that only reads. Each port has its own clock and its own address bus, and the two ports may use different data widths. Data written as narrow words can therefore be read back as wide words, or the other way round. This makes the memory a width converter between two clock domains as well as a store.

Parameters set the shape of each port, the polarity of each enable, the active clock edge of each port, and whether the read data passes through one extra register. There is no flow control. A write happens on every active write edge at which the write enable is asserted. A read word is produced on every active read edge at which the read enable is asserted. The two ports take no account of each other, and nothing detects a read and a write to the same location in the same period.

Top module: `mwram_top`

## Requirements
- R1: Each port is one of the shapes width×depth 1×4096, 2×2048, 4×1024, 9×512, 18×256 or 36×128. Its address width is log2 of its depth, and every address in 0..depth-1 selects distinct storage. An initial assertion rejects a configuration whose read width×depth differs from its write width×depth, or whose shape is not in that list.
- R2: When the write port is narrower than the read port, wide read word k holds narrow words k·R .. k·R+R-1, where R is the width ratio. Narrow word k·R+i occupies bits [i·W +: W] of the wide word, with i=0 in the least-significant bits and W the narrow width. In other words, the narrow address is the wide address followed by the sub-word index i.
- R3: When the write port is wider than the read port, the same mapping applies in reverse. Narrow read address k·R+i returns bits [i·W +: W] of the wide word written at wide address k.
- R4: The write enable mode is 1 for active high, 0 for active low, or 2 for unused. In mode 2 a write occurs on every active write edge. A write attempted with an inactive enable leaves the stored word unchanged.
- R5: The read enable uses the same three modes. While the read enable is inactive, the read output holds its value, and so does the extra pipeline register when it is present. In mode 2 a new word is read on every active read edge.
- R6: With the pipeline off, the read data shows the word addressed at an active read edge right after that edge. With the pipeline on, it shows that word after the following active read edge.
- R7: Each port's active edge is selected on its own: 0 selects the rising edge and 1 selects the falling edge.
- R8: The read reset is active high and sampled on the active read edge. It clears the read output register and the pipeline register to zero, and it takes priority over the read enable. The memory contents are not reset and remain readable afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write clock; edge chosen by WR_FALL |
| wr_en | input | 1 | Write enable; meaning set by WR_EN_MODE |
| wr_addr | input | log2(WR_DEPTH) | Write word address |
| wr_data | input | WR_WIDTH | Write data |
| rd_clk | input | 1 | Read clock; edge chosen by RD_FALL |
| rd_rst | input | 1 | Synchronous read-side reset, active high |
| rd_en | input | 1 | Read enable; meaning set by RD_EN_MODE |
| rd_addr | input | log2(RD_DEPTH) | Read word address |
| rd_data | output | RD_WIDTH | Registered read data |

## Verification
Two read-side functions can fall on the same active read edge: the read reset and an enabled read. The bench provokes this by asserting the reset while the read enable is high and the read address changes on every cycle. The output must read zero on both bench instances, which shows that the reset wins. The bench then reads a location that was written before the reset and expects its original contents, which shows that the storage itself was not cleared. Writes and reads to the same address in one period are never mixed, because that result is undefined.

// File: rtl/mwram_pkg.sv
package mwram_pkg;

  localparam int EN_LOW  = 0;
  localparam int EN_HIGH = 1;
  localparam int EN_NONE = 2;

  function automatic logic en_act(int mode, logic en);
    case (mode)
      EN_LOW:  return ~en;
      EN_HIGH: return en;
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit shape_ok(int w, int d);
    return (w == 1  && d == 4096) || (w == 2  && d == 2048) ||
           (w == 4  && d == 1024) || (w == 9  && d == 512)  ||
           (w == 18 && d == 256)  || (w == 36 && d == 128);
  endfunction

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/mwram_port_ctl.sv
module mwram_port_ctl
  import mwram_pkg::*;
#(
  parameter int EN_MODE = EN_HIGH,
  parameter int FALL    = 0
) (
  input  logic clk_in,
  input  logic en_in,
  output logic clk_out,
  output logic act
);

  initial begin
    AST_EN_MODE_RANGE: assert (EN_MODE >= 0 && EN_MODE <= 2) else $error("bad enable mode"); // R4
  end

  generate
    if (FALL != 0) begin : g_fall
      assign clk_out = ~clk_in;
    end else begin : g_rise
      assign clk_out = clk_in;
    end
  endgenerate

  assign act = en_act(EN_MODE, en_in);

endmodule

// File: rtl/mwram_store.sv
module mwram_store #(
  parameter int NW     = 9,
  parameter int ND     = 512,
  parameter int WR_RAT = 1,
  parameter int RD_RAT = 4,
  localparam int NAW   = $clog2(ND),
  localparam int WAW   = NAW - $clog2(WR_RAT),
  localparam int RAW   = NAW - $clog2(RD_RAT)
) (
  input  logic                 wclk,
  input  logic                 we,
  input  logic [WAW-1:0]       waddr,
  input  logic [WR_RAT*NW-1:0] wdata,
  input  logic                 rclk,
  input  logic                 rrst,
  input  logic                 re,
  input  logic [RAW-1:0]       raddr,
  output logic [RD_RAT*NW-1:0] q
);

  logic [NW-1:0] mem [ND];

  always_ff @(posedge wclk) begin
    if (we) begin
      for (int i = 0; i < WR_RAT; i++) begin
        mem[NAW'(waddr) * NAW'(WR_RAT) + NAW'(i)] <= wdata[i*NW +: NW];
      end
    end
  end

  always_ff @(posedge rclk) begin
    if (rrst) begin
      q <= '0;
    end else if (re) begin
      for (int i = 0; i < RD_RAT; i++) begin
        q[i*NW +: NW] <= mem[NAW'(raddr) * NAW'(RD_RAT) + NAW'(i)];
      end
    end
  end

  AST_STAGE_HOLD: assert property (@(posedge rclk) disable iff (rrst)
    !re |=> $stable(q)) else $error("read stage moved while disabled"); // R5

  AST_STAGE_CLEAR: assert property (@(posedge rclk)
    rrst |=> (q == '0)) else $error("read stage not cleared by reset"); // R8

endmodule

// File: rtl/mwram_rpipe.sv
module mwram_rpipe #(
  parameter int W    = 36,
  parameter int PIPE = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         re,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  generate
    if (PIPE != 0) begin : g_pipe
      logic [W-1:0] q2;
      always_ff @(posedge clk) begin
        if (rst)     q2 <= '0;
        else if (re) q2 <= din;
      end
      assign dout = q2;
    end else begin : g_bypass
      assign dout = din;
    end
  endgenerate

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !re |=> $stable(dout)) else $error("read output moved while disabled"); // R5

  AST_OUT_CLEAR: assert property (@(posedge clk)
    rst |=> (dout == '0)) else $error("read output not cleared by reset"); // R8

endmodule

// File: rtl/mwram_top.sv
module mwram_top
  import mwram_pkg::*;
#(
  parameter int WR_WIDTH   = 9,
  parameter int WR_DEPTH   = 512,
  parameter int RD_WIDTH   = 36,
  parameter int RD_DEPTH   = 128,
  parameter int WR_EN_MODE = EN_HIGH,
  parameter int RD_EN_MODE = EN_HIGH,
  parameter int WR_FALL    = 0,
  parameter int RD_FALL    = 0,
  parameter int RD_PIPE    = 0,
  localparam int WAW       = $clog2(WR_DEPTH),
  localparam int RAW       = $clog2(RD_DEPTH)
) (
  input  logic                wr_clk,
  input  logic                wr_en,
  input  logic [WAW-1:0]      wr_addr,
  input  logic [WR_WIDTH-1:0] wr_data,
  input  logic                rd_clk,
  input  logic                rd_rst,
  input  logic                rd_en,
  input  logic [RAW-1:0]      rd_addr,
  output logic [RD_WIDTH-1:0] rd_data
);

  localparam int NW     = imin(WR_WIDTH, RD_WIDTH);
  localparam int ND     = imax(WR_DEPTH, RD_DEPTH);
  localparam int WR_RAT = WR_WIDTH / NW;
  localparam int RD_RAT = RD_WIDTH / NW;

  initial begin
    AST_SHAPE_LEGAL: assert (shape_ok(WR_WIDTH, WR_DEPTH) && shape_ok(RD_WIDTH, RD_DEPTH))
      else $error("port shape not supported"); // R1
    AST_CAPACITY_MATCH: assert (WR_WIDTH * WR_DEPTH == RD_WIDTH * RD_DEPTH)
      else $error("read and write capacity differ"); // R1
  end

  logic wclk_i, we_i, rclk_i, re_i;
  logic [RD_WIDTH-1:0] stage_q;

  mwram_port_ctl #(.EN_MODE(WR_EN_MODE), .FALL(WR_FALL)) u_wctl (
    .clk_in(wr_clk), .en_in(wr_en), .clk_out(wclk_i), .act(we_i)
  );

  mwram_port_ctl #(.EN_MODE(RD_EN_MODE), .FALL(RD_FALL)) u_rctl (
    .clk_in(rd_clk), .en_in(rd_en), .clk_out(rclk_i), .act(re_i)
  );

  mwram_store #(.NW(NW), .ND(ND), .WR_RAT(WR_RAT), .RD_RAT(RD_RAT)) u_store (
    .wclk(wclk_i), .we(we_i), .waddr(wr_addr), .wdata(wr_data),
    .rclk(rclk_i), .rrst(rd_rst), .re(re_i), .raddr(rd_addr), .q(stage_q)
  );

  mwram_rpipe #(.W(RD_WIDTH), .PIPE(RD_PIPE)) u_rpipe (
    .clk(rclk_i), .rst(rd_rst), .re(re_i), .din(stage_q), .dout(rd_data)
  );

endmodule

// File: tb/mwram_top_bench.sv
`timescale 1ns/1ps
module mwram_top_bench;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic wr_clk = 0;
  logic rd_clk = 0;
  always #4    wr_clk = ~wr_clk;
  always #5.5  rd_clk = ~rd_clk;

  logic rd_rst = 1;

  // instance A: 9x512 write (rising, active high) -> 36x128 read (rising, active high, no pipe)
  logic        a_we = 0;
  logic [8:0]  a_waddr = '0;
  logic [8:0]  a_wdata = '0;
  logic        a_re = 0;
  logic [6:0]  a_raddr = '0;
  logic [35:0] a_q;

  // instance B: 36x128 write (falling, active low) -> 9x512 read (falling, no enable, pipe)
  logic        b_we = 1;
  logic [6:0]  b_waddr = '0;
  logic [35:0] b_wdata = '0;
  logic [8:0]  b_raddr = '0;
  logic [8:0]  b_q;

  mwram_top #(
    .WR_WIDTH(9), .WR_DEPTH(512), .RD_WIDTH(36), .RD_DEPTH(128),
    .WR_EN_MODE(1), .RD_EN_MODE(1), .WR_FALL(0), .RD_FALL(0), .RD_PIPE(0)
  ) u_mwram_top (
    .wr_clk(wr_clk), .wr_en(a_we), .wr_addr(a_waddr), .wr_data(a_wdata),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(a_re), .rd_addr(a_raddr), .rd_data(a_q)
  );

  mwram_top #(
    .WR_WIDTH(36), .WR_DEPTH(128), .RD_WIDTH(9), .RD_DEPTH(512),
    .WR_EN_MODE(0), .RD_EN_MODE(2), .WR_FALL(1), .RD_FALL(1), .RD_PIPE(1)
  ) u_mwram_top_rev (
    .wr_clk(wr_clk), .wr_en(b_we), .wr_addr(b_waddr), .wr_data(b_wdata),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(1'b0), .rd_addr(b_raddr), .rd_data(b_q)
  );

  function automatic logic [8:0] fa(int n);
    return 9'((n * 37 + 5) % 512);
  endfunction

  function automatic logic [8:0] fb(int n);
    return 9'((n * 53 + 11) % 512);
  endfunction

  function automatic logic [35:0] exp_a(int k);
    return {fa(4*k+3), fa(4*k+2), fa(4*k+1), fa(4*k)};
  endfunction

  function automatic logic [35:0] word_b(int k);
    return {fb(4*k+3), fb(4*k+2), fb(4*k+1), fb(4*k)};
  endfunction

  task automatic chk(string req, logic [35:0] act, logic [35:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #1600000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // reset state
    repeat (3) @(posedge rd_clk);
    #7;
    chk("R8 reset state A", a_q, 36'h0);
    chk("R8 reset state B", {27'h0, b_q}, 36'h0);
    @(posedge rd_clk); #1 rd_rst = 0;

    // A: narrow writes, every address
    for (int n = 0; n < 512; n++) begin
      @(posedge wr_clk); #2;
      a_we = 1; a_waddr = 9'(n); a_wdata = fa(n);
    end
    // A: inactive-enable junk on addresses 0..15
    for (int n = 0; n < 16; n++) begin
      @(posedge wr_clk); #2;
      a_we = 0; a_waddr = 9'(n); a_wdata = ~fa(n);
    end

    // B: wide writes, active low enable, falling edge
    for (int k = 0; k < 128; k++) begin
      @(negedge wr_clk); #2;
      b_we = 0; b_waddr = 7'(k); b_wdata = word_b(k);
    end
    for (int k = 0; k < 4; k++) begin
      @(negedge wr_clk); #2;
      b_we = 1; b_waddr = 7'(k); b_wdata = ~word_b(k);
    end
    repeat (4) @(posedge wr_clk);

    // A: streaming wide reads, rising edge, one-cycle latency
    for (int k = 0; k <= 128; k++) begin
      @(posedge rd_clk); #1;
      a_re = 1; a_raddr = 7'(k % 128);
      #6;
      if (k >= 1) begin
        if (k - 1 < 4) chk("R4 R2 R6 R7 ignored write A", a_q, exp_a(k-1));
        else           chk("R2 R6 R7 wide read A", a_q, exp_a(k-1));
      end
    end
    // A: read enable low holds output
    @(posedge rd_clk); #1;
    a_re = 0; a_raddr = 7'd5;
    #6 chk("R6 last enabled read A", a_q, exp_a(0));
    for (int c = 0; c < 3; c++) begin
      @(posedge rd_clk); #1;
      a_raddr = 7'(c + 9);
      #6 chk("R5 hold while disabled A", a_q, exp_a(0));
    end

    // B: streaming narrow reads, falling edge, no enable, pipeline
    for (int k = 0; k <= 513; k++) begin
      @(negedge rd_clk); #1;
      b_raddr = 9'(k % 512);
      #6;
      if (k >= 2) begin
        if (k - 2 < 16) chk("R4 R3 R1 ignored write B", {27'h0, b_q}, {27'h0, fb(k-2)});
        else            chk("R3 R1 R5 R6 R7 narrow read B", {27'h0, b_q}, {27'h0, fb(k-2)});
      end
    end

    // reset together with an enabled, moving read
    @(posedge rd_clk); #1;
    rd_rst = 1; a_re = 1;
    for (int c = 0; c < 3; c++) begin
      @(posedge rd_clk); #1;
      a_raddr = 7'(c + 20); b_raddr = 9'(c + 40);
    end
    #6;
    chk("R8 reset beats read enable A", a_q, 36'h0);
    chk("R8 reset beats read B", {27'h0, b_q}, 36'h0);
    @(posedge rd_clk); #1;
    rd_rst = 0; a_raddr = 7'd3; b_raddr = 9'd77;
    @(posedge rd_clk); #7;
    chk("R8 contents survive reset A", a_q, exp_a(3));
    repeat (2) @(posedge rd_clk);
    #7 chk("R8 contents survive reset B", {27'h0, b_q}, {27'h0, fb(77)});

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule